// File: doc/BRIEF.md
# SMBus Byte-Level Master Controller

This block is the byte-level half of an SMBus/I2C master. A CPU drives it through a small byte-wide register file: it writes a command to open a transfer, writes the address byte and data bytes, reads received bytes, and requests a stop. The controller turns these accesses into abstract bus operations (start, write byte, read byte with ACK or NACK, stop) on a request/done transaction port. A separate bit-level engine serves that port, and it returns the target's acknowledge and the read data.

Software is paced by status flags and one interrupt line. A data-ready flag shows when the next byte may be written or a received byte is waiting. An optional stall flag holds the transfer after a positive address acknowledge until software clears it. A sticky negative-acknowledge flag holds off a requested stop until it is cleared. An end-of-busy flag records that a stop has completed. Clearing the enable bit abandons any transfer and returns all of this state to zero.

Register offsets on `reg_addr`: 0 data, 1 status, 2 bus state, 3 command, 4 enable, 5 misc, 6 end-of-busy. Offset 7 reads 0. Bus opcodes on `bus_op`: 0 start, 1 write byte, 2 read byte, 3 stop.

Top module: `smbus_byte_master`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `bus_req` is low.
- R2: A command write (offset 3) with bit 0 (start) set while enabled issues a start. Once it completes, status (offset 1) reads 0x43: bit 6 data-ready, bit 1 master mode, bit 0 transmit. Bus state (offset 2) reads 0x03: bit 0 busy, bit 1 bus busy. The command register reads back with bits 1:0 as 0.
- R3: The first data write after a start is the address byte, the 7-bit address in bits 7:1. Bit 0 set to 1 selects a read, which clears transmit and receives bytes. Bit 0 set to 0 keeps transmit set. Every later data write in transmit mode sends that byte and sets data-ready again when it is acknowledged.
- R4: With command bit 7 (stall enable) set, an acknowledged address also sets status bit 3 (stall), together with data-ready. While stall is set, data writes are ignored and send nothing. Writing 1 to status bit 3 clears it. In receive mode this starts the first byte read.
- R5: A NACK on an address byte sets status bit 4 and leaves data-ready clear. Status reads 0x13 for a write and 0x12 for a read, and `irq` rises when interrupts are enabled.
- R6: Command bit 1 (stop) reads back as 0. The stop is held, with bus state at 0x03, while status bit 4 is set or a received byte is unread. Writing 1 to status bit 4 clears it.
- R7: When the stop completes, status and bus state read 0 and end-of-busy (offset 6, bit 7) is set. Writing 1 to that bit clears it.
- R8: With command bit 4 set, the next byte read is answered with NACK (`bus_nack`=1). Reading that byte starts no further read.
- R9: Writing 0 to enable bit 0 (offset 4) clears the command register, status, bus state and end-of-busy. It drops `bus_req`. Command writes are ignored while the block is disabled.
- R10: Misc register (offset 5) bit 5 is a readable and writable bank select. Its other bits read 0.
- R11: `irq` = command bit 2 AND (data-ready OR NACK OR stall OR (command bit 3 AND end-of-busy)).
- R12: In receive mode, reading the data register returns the received byte and clears data-ready. Unless the byte was the NACKed last one or a stop is pending, the next byte read starts.
- R13: `bus_req` stays high with `bus_op` and `bus_wdata` unchanged until `bus_done`, and drops in the cycle after `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read side effects) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | Bus operation request |
| bus_op | output | 2 | Bus operation code |
| bus_wdata | output | 8 | Byte to send for a write operation |
| bus_nack | output | 1 | For a read: answer the byte with NACK |
| bus_done | input | 1 | One-cycle completion of the requested operation |
| bus_ack | input | 1 | Target acknowledged the written byte |
| bus_rdata | input | 8 | Byte returned by a read operation |

## Verification
A register write or read takes effect at the clock edge that samples the strobe. Flag clears and the read-data side effects show up one cycle later. Any result that needs a bus operation arrives when `bus_done` is sampled. The bench's bus model raises that signal on the third falling edge after the request. A chained case, such as a data read that releases a pending stop, therefore completes within about six cycles. Every bench access waits ten cycles after its strobe before the next one, and the bench samples `reg_rdata` and `irq` just after a falling edge, when all state has settled.

// File: rtl/smbus_byte_master.sv
module smbus_byte_master #(
  parameter logic [6:0] UNUSED_ID = 7'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       bus_req,
  output logic [1:0] bus_op,
  output logic [7:0] bus_wdata,
  output logic       bus_nack,
  input  logic       bus_done,
  input  logic       bus_ack,
  input  logic [7:0] bus_rdata
);
  localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_BST = 3'd2, A_CMD = 3'd3,
                         A_ENA = 3'd4, A_MISC = 3'd5, A_EOB = 3'd6;
  localparam logic [1:0] OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_BUS} state_t;

  state_t     state;
  logic       en, bank, eob, busy, mode, xmit, sdast, negack, stastr;
  logic       addr_phase, rx_mode, rd_due, pend_stop, last, nack_q;
  logic [5:0] ctl;
  logic [1:0] op;
  logic [7:0] tx_byte, rx_byte;

  wire inten   = ctl[0];
  wire eobinte = ctl[1];
  wire ackbit  = ctl[2];
  wire stastre = ctl[5];

  wire wr_data = reg_wr && reg_addr == A_DATA;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire wr_ena  = reg_wr && reg_addr == A_ENA;
  wire wr_misc = reg_wr && reg_addr == A_MISC;
  wire wr_eob  = reg_wr && reg_addr == A_EOB;

  wire start_req = wr_cmd && reg_wdata[0] && state != S_BUS;
  wire tx_ok     = wr_data && xmit && sdast && !stastr && !negack;
  wire rd_take   = reg_rd && reg_addr == A_DATA && rx_mode && sdast && !stastr;
  wire stop_ok   = pend_stop && !negack && !rd_due && !(rx_mode && sdast && !stastr);

  assign bus_req   = state == S_BUS;
  assign bus_op    = op;
  assign bus_wdata = tx_byte;
  assign bus_nack  = nack_q;
  assign irq       = inten && (sdast || negack || stastr || (eobinte && eob));

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = rx_byte;
      A_STAT:  reg_rdata = {1'b0, sdast, 1'b0, negack, stastr, 1'b0, mode, xmit};
      A_BST:   reg_rdata = {6'd0, busy, busy};
      A_CMD:   reg_rdata = {ctl, 2'b00};
      A_ENA:   reg_rdata = {7'd0, en};
      A_MISC:  reg_rdata = {2'd0, bank, 5'd0};
      A_EOB:   reg_rdata = {eob, 7'd0};
      default: reg_rdata = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || (wr_ena && !reg_wdata[0])) begin
      if (!rst_n) bank <= 1'b0;
      state <= S_IDLE;
      en <= 1'b0; eob <= 1'b0; busy <= 1'b0; mode <= 1'b0; xmit <= 1'b0;
      sdast <= 1'b0; negack <= 1'b0; stastr <= 1'b0;
      addr_phase <= 1'b0; rx_mode <= 1'b0; rd_due <= 1'b0;
      pend_stop <= 1'b0; last <= 1'b0; nack_q <= 1'b0;
      ctl <= 6'd0; op <= OP_START; tx_byte <= 8'd0; rx_byte <= 8'd0;
    end else begin
      if (wr_ena) en <= 1'b1;
      if (wr_misc) bank <= reg_wdata[5];
      if (wr_eob && reg_wdata[7]) eob <= 1'b0;
      if (en) begin
        if (wr_cmd) begin
          ctl <= reg_wdata[7:2];
          if (reg_wdata[1] && mode) pend_stop <= 1'b1;
        end
        if (wr_stat && reg_wdata[4]) negack <= 1'b0;
        if (wr_stat && reg_wdata[3] && stastr) begin
          stastr <= 1'b0;
          if (rx_mode) begin
            sdast  <= 1'b0;
            rd_due <= 1'b1;
          end
        end
        case (state)
          S_IDLE, S_HOLD: begin
            if (start_req) begin
              op <= OP_START; state <= S_BUS;
              busy <= 1'b1; mode <= 1'b1;
              sdast <= 1'b0; negack <= 1'b0; stastr <= 1'b0;
              rx_mode <= 1'b0; rd_due <= 1'b0; last <= 1'b0; pend_stop <= 1'b0;
            end else if (state == S_HOLD) begin
              if (rd_due) begin
                op <= OP_READ; nack_q <= ackbit; rd_due <= 1'b0; state <= S_BUS;
              end else if (tx_ok) begin
                op <= OP_WRITE; tx_byte <= reg_wdata; sdast <= 1'b0; state <= S_BUS;
              end else if (rd_take) begin
                sdast <= 1'b0;
                if (!last && !pend_stop) rd_due <= 1'b1;
              end else if (stop_ok) begin
                op <= OP_STOP; state <= S_BUS;
              end
            end
          end
          S_BUS: if (bus_done) begin
            state <= S_HOLD;
            case (op)
              OP_START: begin
                sdast <= 1'b1; xmit <= 1'b1; addr_phase <= 1'b1;
              end
              OP_WRITE: begin
                if (addr_phase) begin
                  addr_phase <= 1'b0;
                  xmit <= !tx_byte[0];
                  rx_mode <= tx_byte[0];
                end
                if (!bus_ack) negack <= 1'b1;
                else if (addr_phase && stastre) begin
                  stastr <= 1'b1; sdast <= 1'b1;
                end else if (addr_phase && tx_byte[0]) rd_due <= 1'b1;
                else sdast <= 1'b1;
              end
              OP_READ: begin
                rx_byte <= bus_rdata; sdast <= 1'b1; last <= nack_q;
              end
              default: begin
                state <= S_IDLE;
                mode <= 1'b0; xmit <= 1'b0; sdast <= 1'b0; stastr <= 1'b0;
                busy <= 1'b0; eob <= 1'b1; pend_stop <= 1'b0;
                rx_mode <= 1'b0; last <= 1'b0;
              end
            endcase
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^UNUSED_ID;
endmodule

module smbus_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic [7:0] reg_wdata,
  input logic       bus_req,
  input logic       bus_done,
  input logic [1:0] bus_op,
  input logic [7:0] bus_wdata,
  input logic       irq,
  input logic       busy,
  input logic       negack,
  input logic       inten,
  input logic       eob
);
  wire dis_wr = reg_wr && reg_addr == 3'd4 && !reg_wdata[0];

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done && !dis_wr) |=> (bus_req && $stable(bus_op) && $stable(bus_wdata)));

  assert_req_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done) |=> !bus_req);

  assert_nack_keeps_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    negack |-> busy);

  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !inten |-> !irq);

  assert_nack_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inten && negack) |-> irq);

  assert_disable_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dis_wr |=> (!bus_req && !irq && !busy && !eob));

  assert_eob_after_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eob) |-> !busy);
endmodule

bind smbus_byte_master smbus_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .bus_req(bus_req), .bus_done(bus_done), .bus_op(bus_op), .bus_wdata(bus_wdata),
  .irq(irq), .busy(busy), .negack(negack), .inten(ctl[0]), .eob(eob)
);

// File: tb/smbus_byte_master_test.sv
module smbus_byte_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic irq, bus_req, bus_nack;
  logic [1:0] bus_op;
  logic [7:0] bus_wdata;
  logic bus_done = 1'b0, bus_ack = 1'b0;
  logic [7:0] bus_rdata = 8'd0;

  always #5 clk = ~clk;

  smbus_byte_master uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .bus_req(bus_req),
    .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_nack(bus_nack), .bus_done(bus_done),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // bus model: one target at 0x48 that remembers its last data byte
  int cnt = 0, n_wr = 0, n_rd = 0, n_nack = 0;
  logic want_addr = 1'b0;
  logic [7:0] mem = 8'd0;
  always @(negedge clk) begin
    if (!rst_n || bus_done) begin
      bus_done = 1'b0; cnt = 0;
    end else if (!bus_req) cnt = 0;
    else if (cnt == 2) begin
      cnt = 0; bus_done = 1'b1;
      case (bus_op)
        2'd0: want_addr = 1'b1;
        2'd1: begin
          n_wr++;
          if (want_addr) begin
            bus_ack = (bus_wdata[7:1] == 7'h48); want_addr = 1'b0;
          end else begin
            bus_ack = 1'b1; mem = bus_wdata;
          end
        end
        2'd2: begin
          n_rd++; bus_rdata = mem;
          if (bus_nack) n_nack++;
        end
        default: ;
      endcase
    end else cnt++;
  end

  int checks = 0, errors = 0;
  bit done_flag = 1'b0;

  task automatic chk(input int tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic do_w(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic do_c(input logic [2:0] a, input logic [7:0] e, input int tag);
    logic [7:0] got;
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 got = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
    chk(tag, got, e);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_i(input logic e, input int tag);
    @(negedge clk); #1 chk(tag, {7'd0, irq}, {7'd0, e});
  endtask

  localparam logic [1:0] KW = 2'd0, KC = 2'd1, KI = 2'd2;
  localparam int NV = 42;
  // {kind, offset, write data / irq, expected, tag}
  localparam logic [24:0] VEC [NV] = '{
    {KW, 3'd4, 8'h01, 8'h00, 4'd9},   // R9 enable
    {KC, 3'd1, 8'h00, 8'h00, 4'd1},   // R1
    {KI, 3'd0, 8'h00, 8'h00, 4'd11},  // R11 quiet
    {KW, 3'd3, 8'h85, 8'h00, 4'd2},   // R2 start, inten, stall enable
    {KC, 3'd3, 8'h00, 8'h84, 4'd2},   // R2 start reads 0
    {KC, 3'd1, 8'h00, 8'h43, 4'd2},   // R2
    {KC, 3'd2, 8'h00, 8'h03, 4'd2},   // R2
    {KI, 3'd0, 8'h01, 8'h00, 4'd11},  // R11 data-ready
    {KW, 3'd0, 8'h90, 8'h00, 4'd3},   // R3 write to 0x48
    {KC, 3'd1, 8'h00, 8'h4B, 4'd4},   // R4 stall
    {KW, 3'd0, 8'h55, 8'h00, 4'd4},   // R4 ignored
    {KC, 3'd1, 8'h00, 8'h4B, 4'd4},   // R4
    {KW, 3'd1, 8'h08, 8'h00, 4'd4},   // R4 release
    {KC, 3'd1, 8'h00, 8'h43, 4'd4},   // R4
    {KW, 3'd0, 8'h0A, 8'h00, 4'd3},   // R3
    {KW, 3'd0, 8'h60, 8'h00, 4'd3},   // R3
    {KC, 3'd1, 8'h00, 8'h43, 4'd3},   // R3
    {KW, 3'd3, 8'h8E, 8'h00, 4'd6},   // R6 stop
    {KC, 3'd3, 8'h00, 8'h8C, 4'd6},   // R6 stop reads 0
    {KC, 3'd1, 8'h00, 8'h00, 4'd7},   // R7
    {KC, 3'd2, 8'h00, 8'h00, 4'd7},   // R7
    {KC, 3'd6, 8'h00, 8'h80, 4'd7},   // R7
    {KI, 3'd0, 8'h01, 8'h00, 4'd11},  // R11 end-of-busy
    {KW, 3'd6, 8'h80, 8'h00, 4'd7},   // R7 clear
    {KC, 3'd6, 8'h00, 8'h00, 4'd7},   // R7
    {KI, 3'd0, 8'h00, 8'h00, 4'd11},  // R11
    {KW, 3'd3, 8'h85, 8'h00, 4'd2},   // R2
    {KW, 3'd0, 8'h91, 8'h00, 4'd3},   // R3 read from 0x48
    {KC, 3'd1, 8'h00, 8'h4A, 4'd3},   // R3 receive with stall
    {KW, 3'd1, 8'h08, 8'h00, 4'd4},   // R4 release starts read
    {KC, 3'd1, 8'h00, 8'h42, 4'd12},  // R12
    {KC, 3'd0, 8'h00, 8'h60, 4'd12},  // R12 byte 1
    {KW, 3'd3, 8'h94, 8'h00, 4'd8},   // R8 NACK next
    {KC, 3'd0, 8'h00, 8'h60, 4'd12},  // R12 byte 2
    {KC, 3'd1, 8'h00, 8'h42, 4'd8},   // R8 last byte waiting
    {KW, 3'd3, 8'h8E, 8'h00, 4'd6},   // R6 stop
    {KC, 3'd2, 8'h00, 8'h03, 4'd6},   // R6 held by unread byte
    {KC, 3'd0, 8'h00, 8'h60, 4'd12},  // R12 byte 3
    {KC, 3'd1, 8'h00, 8'h00, 4'd7},   // R7
    {KC, 3'd2, 8'h00, 8'h00, 4'd7},   // R7
    {KC, 3'd6, 8'h00, 8'h80, 4'd7},   // R7
    {KW, 3'd6, 8'h80, 8'h00, 4'd7}    // R7
  };

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 7; a++) do_c(a[2:0], 8'h00, 1);
    do_i(1'b0, 1);
    chk(1, {7'd0, bus_req}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][24:23])
        KW: do_w(VEC[i][22:20], VEC[i][19:12]);
        KC: do_c(VEC[i][22:20], VEC[i][11:4], int'(VEC[i][3:0]));
        default: do_i(VEC[i][12], int'(VEC[i][3:0]));
      endcase
    end
    chk(4, n_wr[7:0], 8'd4);    // R4 stalled write not sent
    chk(12, n_rd[7:0], 8'd3);   // R12 reads chain on data reads
    chk(8, n_nack[7:0], 8'd1);  // R8 only the last read NACKed

    // R5 write-address NACK, R6 stop held until NACK cleared
    do_w(3'd3, 8'h85);
    do_w(3'd0, 8'h02);
    do_c(3'd1, 8'h13, 5);
    do_i(1'b1, 5);
    do_w(3'd3, 8'h8E);
    do_c(3'd2, 8'h03, 6);
    do_c(3'd1, 8'h13, 6);
    do_w(3'd1, 8'h10);
    do_c(3'd1, 8'h00, 6);
    do_c(3'd2, 8'h00, 6);
    do_c(3'd6, 8'h80, 7);

    // R9 disable clears and blocks commands
    do_w(3'd4, 8'h00);
    do_c(3'd6, 8'h00, 9);
    do_c(3'd3, 8'h00, 9);
    do_c(3'd1, 8'h00, 9);
    do_w(3'd3, 8'h85);
    do_c(3'd2, 8'h00, 9);
    chk(13, {7'd0, bus_req}, 8'h00);  // R13 no request when idle

    // R5 read-address NACK, then R9 disable mid-transfer
    do_w(3'd4, 8'h01);
    do_w(3'd3, 8'h85);
    do_w(3'd0, 8'h03);
    do_c(3'd1, 8'h12, 5);
    do_w(3'd4, 8'h00);
    do_c(3'd2, 8'h00, 9);
    do_c(3'd1, 8'h00, 9);

    // R11 no interrupt without enable bit
    do_w(3'd4, 8'h01);
    do_w(3'd3, 8'h01);
    do_c(3'd1, 8'h43, 11);
    do_i(1'b0, 11);
    do_w(3'd4, 8'h00);

    // R10 bank select
    do_w(3'd5, 8'hFF);
    do_c(3'd5, 8'h20, 10);
    do_w(3'd5, 8'h00);
    do_c(3'd5, 8'h00, 10);

    finish_run();
  end
endmodule